// File: doc/BRIEF.md
# Gated-Window Frequency Meter

The block measures the frequency of a clock by counting its rising edges during a gate window of fixed length. A timebase counter runs on the reference clock. Its core wraps a set number of times, and the gate closes when the last wrap occurs. The gate length is chosen so that the edge count reads directly as the frequency, with no division. A second counter runs in the measured clock domain. It has a core word and an extension word that counts the core's wraps, and it accumulates edges while a synchronized copy of the gate is high.

The gate opens and closes through the same synchronizer. The measured-domain counter therefore sees a window of the same length as the reference gate, delayed by a fixed number of its own edges. Hardware closes the gate, so both counters freeze at a defined edge and no software stop loop is involved. After the count freezes, a toggle handshake returns it to the reference domain. There it is latched into `count_o`, and a single-cycle `done_o` marks the new result.

Software raises `start_i` for one cycle while the meter is idle. It then waits for `done_o` and reads `count_o` together with `overrange_o`.

Top module: `fm_gated_meter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, gate_o, done_o and overrange_o are low and count_o is zero.
- R2: A start_i sampled high at a reference edge while idle raises gate_o after that edge. The gate then stays high for exactly TERM_WRAPS x 2^TB_W reference cycles, which is TERM_WRAPS wraps of a TB_W-bit timebase core (defaults 1024 and 16).
- R3: start_i has no effect while the gate is open or while a result is still on its way back. The gate_o timing of the running measurement is unchanged, and no extra window opens.
- R4: A rising edge of the measured clock is counted only when gate_o, as sampled by the measured clock two of its edges earlier, was high. Each new window counts from zero.
- R5: The delivered count_o equals the number of counted edges modulo 2^(PC_W+PC_EXT_W).
- R6: overrange_o is delivered high exactly when the counted edges in the window exceed 2^(PC_W+PC_EXT_W)-1.
- R7: done_o is high for one reference cycle per measurement. count_o and overrange_o change only in that cycle and hold at all other times.
- R8: done_o follows gate close after at least 3 reference cycles and at most ceil(3 measured periods / reference period) + 3 reference cycles.
- R9: A new measurement discards the previous count and overrange state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock for timebase, control and result |
| sig_clk_i | input | 1 | Clock under measurement |
| rst_ni | input | 1 | Asynchronous reset, active low, both domains |
| start_i | input | 1 | Begin a measurement (reference domain) |
| gate_o | output | 1 | Gate window open (reference domain) |
| done_o | output | 1 | One-cycle pulse, new result valid |
| count_o | output | PC_W+PC_EXT_W | Edge count of the last window |
| overrange_o | output | 1 | Last window overflowed the count width |

## Verification
The bench drives a fast measured clock whose edge count in the window runs past the extended counter width. A design that dropped the extension carry or failed to flag the wrap would deliver a plain wrapped count with overrange_o low. It fires start_i in the middle of an open gate and again in the gap before done_o. A design that rearmed there would stretch or reopen the window, which the per-cycle gate comparison catches. Back-to-back windows at three different rates check that counts and the overrange flag do not carry over. A slow measured clock stresses the close handshake, so a result that is latched too early or too late falls outside the latency bound or delivers a stale count.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GATE = 2'd1,
    ST_WAIT = 2'd2
  } meter_state_e;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[0] <= 1'b0;
          else         sr_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) sr_q[s] <= 1'b0;
          else         sr_q[s] <= sr_q[s-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/fm_timebase.sv
module fm_timebase #(
  parameter int TB_W       = 16,
  parameter int TERM_WRAPS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic term_o
);
  localparam int EXT_W = (TERM_WRAPS > 1) ? $clog2(TERM_WRAPS) : 1;
  localparam logic [EXT_W-1:0] LAST_WRAP = EXT_W'(TERM_WRAPS - 1);

  logic [TB_W-1:0]  core_q;
  logic [EXT_W-1:0] wraps_q;
  logic             core_full;

  assign core_full = &core_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q  <= '0;
      wraps_q <= '0;
    end else if (clear_i) begin
      core_q  <= '0;
      wraps_q <= '0;
    end else if (run_i) begin
      core_q <= core_q + TB_W'(1);
      if (core_full) wraps_q <= wraps_q + EXT_W'(1);
    end
  end

  // last tick of the final wrap closes the gate
  assign term_o = run_i && core_full && (wraps_q == LAST_WRAP);
endmodule

// File: rtl/fm_pulse_counter.sv
module fm_pulse_counter #(
  parameter int PC_W        = 16,
  parameter int PC_EXT_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     sig_clk_i,
  input  logic                     rst_ni,
  input  logic                     gate_i,
  output logic [PC_W+PC_EXT_W-1:0] cnt_o,
  output logic                     ovr_o,
  output logic                     req_tog_o,
  output logic                     gate_sync_o
);
  logic                gate_s, gate_d;
  logic                open_evt, close_evt;
  logic [PC_W-1:0]     core_q;
  logic [PC_EXT_W-1:0] ext_q;
  logic                ovr_q, tog_q;

  fm_sync #(.STAGES(SYNC_STAGES)) i_gate_sync (
    .clk_i (sig_clk_i),
    .rst_ni(rst_ni),
    .d_i   (gate_i),
    .q_o   (gate_s)
  );

  always_ff @(posedge sig_clk_i or negedge rst_ni)
    if (!rst_ni) gate_d <= 1'b0;
    else         gate_d <= gate_s;

  assign open_evt  = gate_s & ~gate_d;
  assign close_evt = ~gate_s & gate_d;

  always_ff @(posedge sig_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q <= '0;
      ext_q  <= '0;
      ovr_q  <= 1'b0;
    end else if (open_evt) begin
      // opening edge is the first counted edge
      core_q <= PC_W'(1);
      ext_q  <= '0;
      ovr_q  <= 1'b0;
    end else if (gate_s) begin
      core_q <= core_q + PC_W'(1);
      if (&core_q) begin
        ext_q <= ext_q + PC_EXT_W'(1);
        if (&ext_q) ovr_q <= 1'b1;
      end
    end
  end

  // one toggle per window, raised once the count is frozen
  always_ff @(posedge sig_clk_i or negedge rst_ni)
    if (!rst_ni)        tog_q <= 1'b0;
    else if (close_evt) tog_q <= ~tog_q;

  assign cnt_o       = {ext_q, core_q};
  assign ovr_o       = ovr_q;
  assign req_tog_o   = tog_q;
  assign gate_sync_o = gate_s;
endmodule

// File: rtl/fm_result_cap.sv
module fm_result_cap #(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             req_tog_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovr_i,
  output logic             evt_o,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ovr_o
);
  logic             req_s, req_d, done_q, ovr_q;
  logic [CNT_W-1:0] count_q;

  fm_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tog_i),
    .q_o   (req_s)
  );

  assign evt_o = arm_i & (req_s ^ req_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_d   <= 1'b0;
      done_q  <= 1'b0;
      count_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      req_d  <= req_s;
      done_q <= evt_o;
      // source bus has been static for the whole sync delay
      if (evt_o) begin
        count_q <= cnt_i;
        ovr_q   <= ovr_i;
      end
    end
  end

  assign done_o  = done_q;
  assign count_o = count_q;
  assign ovr_o   = ovr_q;
endmodule

// File: rtl/fm_gated_meter.sv
module fm_gated_meter
  import fm_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int TERM_WRAPS  = 1024,
  parameter int PC_W        = 16,
  parameter int PC_EXT_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     ref_clk_i,
  input  logic                     sig_clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logic                     gate_o,
  output logic                     done_o,
  output logic [PC_W+PC_EXT_W-1:0] count_o,
  output logic                     overrange_o
);
  localparam int CNT_W = PC_W + PC_EXT_W;

  meter_state_e     state_q, state_d;
  logic             start_acc, term, res_evt;
  logic [CNT_W-1:0] pc_cnt;
  logic             pc_ovr, pc_tog, pc_gate_sync;

  assign start_acc = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_GATE;
      ST_GATE: if (term)    state_d = ST_WAIT;
      ST_WAIT: if (res_evt) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign gate_o = (state_q == ST_GATE);

  fm_timebase #(.TB_W(TB_W), .TERM_WRAPS(TERM_WRAPS)) i_timebase (
    .clk_i  (ref_clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_acc),
    .run_i  (gate_o),
    .term_o (term)
  );

  fm_pulse_counter #(
    .PC_W(PC_W), .PC_EXT_W(PC_EXT_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_pulse_counter (
    .sig_clk_i  (sig_clk_i),
    .rst_ni     (rst_ni),
    .gate_i     (gate_o),
    .cnt_o      (pc_cnt),
    .ovr_o      (pc_ovr),
    .req_tog_o  (pc_tog),
    .gate_sync_o(pc_gate_sync)
  );

  fm_result_cap #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_result_cap (
    .clk_i    (ref_clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (state_q == ST_WAIT),
    .req_tog_i(pc_tog),
    .cnt_i    (pc_cnt),
    .ovr_i    (pc_ovr),
    .evt_o    (res_evt),
    .done_o   (done_o),
    .count_o  (count_o),
    .ovr_o    (overrange_o)
  );
endmodule

// File: rtl/fm_gated_meter_chk.sv
module fm_gated_meter_chk
  import fm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             ref_clk_i,
  input logic             sig_clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             gate_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_o,
  input logic             overrange_o,
  input meter_state_e     state_q,
  input logic [CNT_W-1:0] pulse_cnt,
  input logic             gate_sync
);
  // R7
  done_pulse_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(count_o) && $stable(overrange_o)));

  // R2
  gate_open_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(start_i));

  // R3
  no_rearm_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && start_i) |=> !gate_o);

  // R8
  done_after_close_chk: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    done_o |-> (!gate_o && $past(state_q) == ST_WAIT));

  // R4
  frozen_count_chk: assert property (@(posedge sig_clk_i) disable iff (!rst_ni)
    !gate_sync |=> $stable(pulse_cnt));
endmodule

bind fm_gated_meter fm_gated_meter_chk #(.CNT_W(PC_W + PC_EXT_W)) i_fm_chk (
  .ref_clk_i  (ref_clk_i),
  .sig_clk_i  (sig_clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .gate_o     (gate_o),
  .done_o     (done_o),
  .count_o    (count_o),
  .overrange_o(overrange_o),
  .state_q    (state_q),
  .pulse_cnt  (pc_cnt),
  .gate_sync  (pc_gate_sync)
);

// File: tb/test_fm_gated_meter.sv
module test_fm_gated_meter;
  // delays in ps; 8000 ps reference period (125 MHz)
  localparam int TB_W     = 5;
  localparam int TERM     = 4;
  localparam int PC_W     = 4;
  localparam int PC_EXT_W = 4;
  localparam int CNT_W    = PC_W + PC_EXT_W;
  localparam int GATE_N   = TERM << TB_W;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  logic             ref_clk = 1'b0;
  logic             sig_clk = 1'b0;
  logic             rst_n   = 1'b0;
  logic             start   = 1'b0;
  logic             gate_o, done_o, overrange_o;
  logic [CNT_W-1:0] count_o;

  int sig_half = 2600;
  int checks = 0;
  int fails  = 0;
  bit run_chk = 1'b0;

  fm_gated_meter #(
    .TB_W(TB_W), .TERM_WRAPS(TERM), .PC_W(PC_W), .PC_EXT_W(PC_EXT_W), .SYNC_STAGES(2)
  ) i_fm_gated_meter (
    .ref_clk_i  (ref_clk),
    .sig_clk_i  (sig_clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .gate_o     (gate_o),
    .done_o     (done_o),
    .count_o    (count_o),
    .overrange_o(overrange_o)
  );

  always #4000 ref_clk = ~ref_clk;

  // sig edges sit at 50 mod 100 ps, never on a reference edge
  initial begin
    #150;
    forever begin
      sig_clk = ~sig_clk;
      #(sig_half);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference-domain model: gate window and busy span
  bit mgate = 0, mbusy = 0, closed = 0;
  int mcyc = 0, lat = 0;
  always @(posedge ref_clk) begin
    if (!rst_n) begin
      mgate = 0; mbusy = 0; mcyc = 0; closed = 0; lat = 0;
    end else begin
      if (closed) lat++;
      if (done_o) begin mbusy = 0; closed = 0; end
      if (mgate) begin
        mcyc++;
        if (mcyc == GATE_N) begin mgate = 0; mbusy = 1; closed = 1; lat = 0; end
      end else if (!mbusy && start) begin
        mgate = 1; mcyc = 0;
      end
    end
  end

  // measured-domain model: edge counted if gate seen two edges earlier
  bit m1 = 0, m2 = 0, m3 = 0, movr = 0;
  int mcnt = 0;
  always @(posedge sig_clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; mcnt = 0; movr = 0;
    end else begin
      if (m2 && !m3) begin
        mcnt = 1; movr = 0;
      end else if (m2) begin
        if (mcnt == CNT_MAX) begin mcnt = 0; movr = 1; end
        else mcnt++;
      end
      m3 = m2; m2 = m1; m1 = gate_o;
    end
  end

  int last_cnt = 0;
  bit last_ovr = 0, prev_done = 0;
  int done_seen = 0;
  always @(negedge ref_clk) begin
    if (rst_n && run_chk) begin
      // R2 R3: gate window matches model every cycle
      check(gate_o == mgate, "R2/R3", "gate_o", int'(gate_o), int'(mgate));
      if (done_o) begin
        done_seen++;
        check(!prev_done, "R7", "done_o width", 2, 1);
        check(int'(count_o) == mcnt, "R5", "count_o", int'(count_o), mcnt);
        check(overrange_o == movr, "R6", "overrange_o", int'(overrange_o), int'(movr));
        check(lat >= 3, "R8", "done latency min", lat, 3);
        check(lat <= (6 * sig_half + 7999) / 8000 + 3, "R8", "done latency max",
              lat, (6 * sig_half + 7999) / 8000 + 3);
        last_cnt = int'(count_o);
        last_ovr = overrange_o;
      end else begin
        check(int'(count_o) == last_cnt, "R7", "count_o hold", int'(count_o), last_cnt);
        check(overrange_o == last_ovr, "R7", "overrange_o hold", int'(overrange_o), int'(last_ovr));
      end
      prev_done = done_o;
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge ref_clk);
    start = 1'b0;
  endtask

  task automatic measure(input int half, input bit poke);
    int seen0;
    sig_half = half;
    repeat (6) @(negedge ref_clk);
    seen0 = done_seen;
    pulse_start();
    if (poke) begin
      // R3: start in the middle of the open gate
      repeat (20) @(negedge ref_clk);
      pulse_start();
    end
    while (gate_o) @(negedge ref_clk);
    // R3: start while the result is still pending
    if (poke) pulse_start();
    for (int i = 0; i < 400 && done_seen == seen0; i++) @(negedge ref_clk);
    check(done_seen == seen0 + 1, "R8", "done_o count", done_seen - seen0, 1);
    repeat (4) @(negedge ref_clk);
    // R3: no window reopened by the ignored starts
    check(!gate_o && !done_o, "R3", "idle after result", int'(gate_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge ref_clk);
    // R1: reset state
    check(!gate_o, "R1", "gate_o in reset", int'(gate_o), 0);
    check(!done_o, "R1", "done_o in reset", int'(done_o), 0);
    check(count_o == '0, "R1", "count_o in reset", int'(count_o), 0);
    check(!overrange_o, "R1", "overrange_o in reset", int'(overrange_o), 0);
    rst_n = 1'b1;
    @(negedge ref_clk);
    check(!gate_o && !done_o && count_o == '0 && !overrange_o, "R1", "after reset",
          int'(count_o), 0);
    run_chk = 1'b1;

    measure(2600, 1'b0);   // R4 R5: mid-rate input
    measure(10900, 1'b1);  // R3 R8: slow input, ignored starts
    measure(1600, 1'b0);   // R6: window overflows the count width
    check(overrange_o, "R6", "overrange flagged", int'(overrange_o), 1);
    measure(2600, 1'b0);   // R9: fresh window after overrange
    check(!overrange_o, "R9", "overrange cleared", int'(overrange_o), 0);
    check(int'(count_o) > 180 && int'(count_o) < 210, "R9", "count plausible",
          int'(count_o), 197);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule